// File: doc/BRIEF.md
# Byte-Lane SEC-DED Protected SRAM

A synchronous model of a 16-bit static memory. Each of the two byte lanes is kept in its own 13-bit codeword: 8 data bits, 4 Hamming check bits and one overall parity bit. A lane is encoded when it is written. On a read it is decoded and corrected, so byte-masked writes never need a read-modify-write. Control inputs are active low: chip select, write enable, output enable, and a separate enable for each byte. Pad tri-states are modelled as per-lane drive-enable outputs plus one enable for the error flags.

Read results appear one clock after the read is accepted. Two flags report the read status. The single flag means at least one enabled lane had a one-bit error that was corrected. The double flag means an enabled lane held an uncorrectable error, so its data is invalid. Both flags can be set together when one lane was corrected and the other was not. A fault-injection port XORs a 13-bit mask straight into a stored codeword so that error handling can be exercised.

Top module: `ecc_sram`

## Requirements
- R1: A word written with both byte enables low is returned unchanged by a later read with both byte enables and output enable low. Data and drive enables are updated at the first clock edge after the read is accepted.
- R2: A write stores only the lanes whose enable is low. The lower enable selects bits 7:0 and the upper enable selects bits 15:8. The other lane keeps its old value.
- R3: In the cycle after a write (chip select and write enable low), no data lane and no flag is driven, even with output enable low.
- R4: In the cycle after a read with output enable low, `rdDataOe[0]` equals the inverse of the lower byte enable and `rdDataOe[1]` the inverse of the upper one. A lane that is not driven reads as zero.
- R5: A read with output enable high drives neither data nor flags.
- R6: In the cycle after chip select is high, nothing is driven and `standby` is 1.
- R7: A single flipped bit anywhere in a lane's 13-bit codeword is corrected on the output. The flag pair reads errSingle=1, errDouble=0. This includes the overall parity bit, whose flip leaves the data untouched.
- R8: Two flipped bits in a lane give errSingle=0 and errDouble=1. Both flags are 0 whenever `errOe` is 0.
- R9: A one-bit error in one lane together with a two-bit error in the other sets both flags.
- R10: Only lanes enabled on the read contribute to the flags, and `errOe` is 1 exactly when at least one lane is driven.
- R11: Corrected data is not written back. A stored fault reports on every read until the lane is rewritten, and the rewrite clears it.
- R12: With `injEn` high, `injMask` is XORed into the codeword of lane `injLane` (0 = bits 7:0, 1 = bits 15:8) at `injAddr`. Codeword bit 0 is the overall parity and bits 1 to 12 are Hamming positions 1 to 12. A write to the same lane in the same cycle wins, and the injection is dropped.
- R13: During reset all outputs are 0 except `standby`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| ubN | input | 1 | Upper byte enable, active low |
| lbN | input | 1 | Lower byte enable, active low |
| addr | input | AW | Word address |
| wrData | input | 16 | Write data |
| injEn | input | 1 | Fault injection strobe |
| injAddr | input | AW | Fault injection address |
| injLane | input | 1 | Fault injection lane |
| injMask | input | 13 | XOR mask applied to the stored codeword |
| rdData | output | 16 | Corrected read data, zero in undriven lanes |
| rdDataOe | output | 2 | Per-lane data drive enable |
| errSingle | output | 1 | Corrected single-bit error flag |
| errDouble | output | 1 | Uncorrectable error flag |
| errOe | output | 1 | Flag drive enable |
| standby | output | 1 | Previous cycle had chip select high |

## Verification
The bench builds the block with DEPTH=16, which keeps a full write-and-read sweep over every address, including both ends of the range, to a few dozen cycles. The codeword width is fixed, so every single-bit position and a set of bit pairs are injected into both lanes within a short run. Mixed-lane cases, masked reads and the write-versus-injection collision follow from there.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int CW_W   = 13;
  localparam int SYN_W  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int DATA_W = LANES * BYTE_W;

  typedef logic [CW_W-1:0] codeWord_t;

  typedef struct packed {
    logic [LANES-1:0] laneWr;
    logic [LANES-1:0] laneRd;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              single;
    logic              dbl;
  } laneResult_t;

  // Bit 0 holds overall parity; bits 1..12 are Hamming positions.
  function automatic codeWord_t eccEncode(input logic [BYTE_W-1:0] d);
    codeWord_t cw;
    int        di;
    logic      acc;
    cw = '0;
    di = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[di];
        di++;
      end
    end
    for (int k = 0; k < SYN_W; k++) begin
      acc = 1'b0;
      for (int p = 1; p < CW_W; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) acc = acc ^ cw[p];
      cw[1 << k] = acc;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic laneResult_t eccDecode(input codeWord_t cw);
    laneResult_t r;
    codeWord_t   fixedCw;
    logic [SYN_W-1:0] syn;
    logic        par;
    int          di;
    syn = '0;
    for (int p = 1; p < CW_W; p++)
      if (cw[p]) syn = syn ^ SYN_W'(p);
    par     = ^cw;
    fixedCw = cw;
    r       = '0;
    if (par) begin
      if (syn == '0) r.single = 1'b1;
      else if (int'(syn) < CW_W) begin
        fixedCw[syn] = ~fixedCw[syn];
        r.single     = 1'b1;
      end else r.dbl = 1'b1;
    end else if (syn != '0) r.dbl = 1'b1;
    di = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[di] = fixedCw[p];
        di++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             weN,
  input  logic             oeN,
  input  logic             ubN,
  input  logic             lbN,
  output ctrlStrobe_t      strobe,
  output logic [LANES-1:0] laneOe,
  output logic             flagOe,
  output logic             standby
);
  logic             wrAcc;
  logic             rdAcc;
  logic [LANES-1:0] laneEn;

  assign wrAcc  = !csN && !weN;
  assign rdAcc  = !csN && weN;
  assign laneEn = ~{ubN, lbN};

  always_comb begin
    strobe.laneWr = wrAcc ? laneEn : '0;
    strobe.laneRd = (rdAcc && !oeN) ? laneEn : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneOe  <= '0;
      flagOe  <= 1'b0;
      standby <= 1'b1;
    end else begin
      laneOe  <= strobe.laneRd;
      flagOe  <= |strobe.laneRd;
      standby <= csN;
    end
  end
endmodule

// File: rtl/ecc_sram_dpath.sv
module ecc_sram_dpath
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injEn,
  input  logic [AW-1:0]     injAddr,
  input  logic [LANE_W-1:0] injLane,
  input  logic [CW_W-1:0]   injMask,
  output logic [DATA_W-1:0] rdData,
  output logic              errSingle,
  output logic              errDouble
);
  logic [DATA_W-1:0] laneData;
  logic [LANES-1:0]  laneSingle;
  logic [LANES-1:0]  laneDbl;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    codeWord_t   mem [DEPTH];
    laneResult_t res;
    logic        injHit;

    assign injHit = injEn && (injLane == LANE_W'(g));

    always_ff @(posedge clk) begin
      if (strobe.laneWr[g])
        mem[addr] <= eccEncode(wrData[g*BYTE_W +: BYTE_W]);
      else if (injHit)
        mem[injAddr] <= mem[injAddr] ^ injMask;
    end

    assign res = eccDecode(mem[addr]);
    assign laneData[g*BYTE_W +: BYTE_W] = strobe.laneRd[g] ? res.data : '0;
    assign laneSingle[g] = strobe.laneRd[g] && res.single;
    assign laneDbl[g]    = strobe.laneRd[g] && res.dbl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      errSingle <= 1'b0;
      errDouble <= 1'b0;
    end else begin
      rdData    <= laneData;
      errSingle <= |laneSingle;
      errDouble <= |laneDbl;
    end
  end
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          weN,
  input  logic          oeN,
  input  logic          ubN,
  input  logic          lbN,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wrData,
  input  logic          injEn,
  input  logic [AW-1:0] injAddr,
  input  logic          injLane,
  input  logic [12:0]   injMask,
  output logic [15:0]   rdData,
  output logic [1:0]    rdDataOe,
  output logic          errSingle,
  output logic          errDouble,
  output logic          errOe,
  output logic          standby
);
  ctrlStrobe_t strobe;

  ecc_sram_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .weN     (weN),
    .oeN     (oeN),
    .ubN     (ubN),
    .lbN     (lbN),
    .strobe  (strobe),
    .laneOe  (rdDataOe),
    .flagOe  (errOe),
    .standby (standby)
  );

  ecc_sram_dpath #(.DEPTH(DEPTH), .AW(AW)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (addr),
    .wrData    (wrData),
    .injEn     (injEn),
    .injAddr   (injAddr),
    .injLane   (injLane),
    .injMask   (injMask),
    .rdData    (rdData),
    .errSingle (errSingle),
    .errDouble (errDouble)
  );
endmodule

// File: rtl/ecc_sram_chk.sv
module ecc_sram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        weN,
  input logic        oeN,
  input logic        ubN,
  input logic        lbN,
  input logic [15:0] rdData,
  input logic [1:0]  rdDataOe,
  input logic        errSingle,
  input logic        errDouble,
  input logic        errOe,
  input logic        standby
);
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN) |=> (rdDataOe == 2'b00 && !errOe)); // R3
  AST_LANE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !oeN) |=> (rdDataOe == ~$past({ubN, lbN}))); // R4
  AST_UNDRIVEN_LO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe[0] |-> (rdData[7:0] == 8'h00)); // R4
  AST_UNDRIVEN_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe[1] |-> (rdData[15:8] == 8'h00)); // R4
  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && oeN) |=> (rdDataOe == 2'b00 && !errOe)); // R5
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (rdDataOe == 2'b00 && !errOe && standby)); // R6
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !errOe |-> (!errSingle && !errDouble)); // R8
  AST_FLAG_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    errOe == (rdDataOe != 2'b00)); // R10
endmodule

bind ecc_sram ecc_sram_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .weN       (weN),
  .oeN       (oeN),
  .ubN       (ubN),
  .lbN       (lbN),
  .rdData    (rdData),
  .rdDataOe  (rdDataOe),
  .errSingle (errSingle),
  .errDouble (errDouble),
  .errOe     (errOe),
  .standby   (standby)
);

// File: tb/ecc_sram_tb_top.sv
module ecc_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int AW         = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1, weN = 1'b1, oeN = 1'b1, ubN = 1'b1, lbN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wrData = '0;
  logic          injEn = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic          injLane = 1'b0;
  logic [12:0]   injMask = '0;
  logic [15:0]   rdData;
  logic [1:0]    rdDataOe;
  logic          errSingle, errDouble, errOe, standby;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    finished = 1'b0;
  string curReq = "R13";

  logic [15:0] mData [DEPTH];
  logic [12:0] mFlt  [DEPTH][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_sram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN), .ubN(ubN), .lbN(lbN),
    .addr(addr), .wrData(wrData), .injEn(injEn), .injAddr(injAddr), .injLane(injLane),
    .injMask(injMask), .rdData(rdData), .rdDataOe(rdDataOe), .errSingle(errSingle),
    .errDouble(errDouble), .errOe(errOe), .standby(standby)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  // One clock: predict from current inputs and model, advance, compare.
  task automatic step();
    logic [1:0]  en, drv, valid;
    logic [15:0] eData;
    logic        eS, eD, rd, wr;
    int          n;
    rd = !csN && weN;
    wr = !csN && !weN;
    en = {!ubN, !lbN};
    drv = (rd && !oeN) ? en : 2'b00;
    eData = '0; eS = 0; eD = 0; valid = 2'b11;
    for (int l = 0; l < 2; l++) begin
      if (drv[l]) begin
        n = $countones(mFlt[addr][l]);
        eData[l*8 +: 8] = mData[addr][l*8 +: 8];
        if (n == 1) eS = 1;
        if (n >= 2) begin eD = 1; valid[l] = 0; end
      end
    end
    @(posedge clk);
    for (int l = 0; l < 2; l++) begin
      if (wr && en[l]) begin
        mData[addr][l*8 +: 8] = wrData[l*8 +: 8];
        mFlt[addr][l] = '0;
      end else if (injEn && int'(injLane) == l) begin
        mFlt[injAddr][l] = mFlt[injAddr][l] ^ injMask;
      end
    end
    @(negedge clk);
    chk("rdDataOe", 32'(rdDataOe), 32'(drv));
    chk("errOe", 32'(errOe), 32'(drv != 2'b00));
    chk("errSingle", 32'(errSingle), 32'(eS));
    chk("errDouble", 32'(errDouble), 32'(eD));
    chk("standby", 32'(standby), 32'(csN));
    if (valid[0]) chk("rdData[7:0]", 32'(rdData[7:0]), 32'(eData[7:0]));
    if (valid[1]) chk("rdData[15:8]", 32'(rdData[15:8]), 32'(eData[15:8]));
  endtask

  task automatic doIdle();
    csN = 1; weN = 0; oeN = 0; ubN = 0; lbN = 0; injEn = 0;
    step();
  endtask

  task automatic doWrite(int a, logic [15:0] d, logic u, logic lo);
    csN = 0; weN = 0; oeN = 0; ubN = u; lbN = lo; addr = AW'(a); wrData = d; injEn = 0;
    step();
  endtask

  task automatic doRead(int a, logic u, logic lo, logic o);
    csN = 0; weN = 1; oeN = o; ubN = u; lbN = lo; addr = AW'(a); injEn = 0;
    step();
  endtask

  task automatic doInject(int a, int lane, logic [12:0] m);
    csN = 1; weN = 1; oeN = 1; ubN = 1; lbN = 1;
    injEn = 1; injAddr = AW'(a); injLane = lane[0]; injMask = m;
    step();
    injEn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mData[a] = '0; mFlt[a][0] = '0; mFlt[a][1] = '0;
    end
    repeat (3) @(negedge clk);
    curReq = "R13";
    chk("reset rdDataOe", 32'(rdDataOe), 0);
    chk("reset errOe", 32'(errOe), 0);
    chk("reset flags", 32'({errSingle, errDouble}), 0);
    chk("reset rdData", 32'(rdData), 0);
    chk("reset standby", 32'(standby), 1);
    rstN = 1;
    @(negedge clk);

    curReq = "R1";
    for (int a = 0; a < DEPTH; a++) doWrite(a, 16'(a * 16'h1111) ^ 16'hA55A, 0, 0);
    for (int a = 0; a < DEPTH; a++) doRead(a, 0, 0, 0);

    curReq = "R2";
    doWrite(3, 16'hFFCC, 1, 0);
    doRead(3, 0, 0, 0);
    doWrite(3, 16'h7700, 0, 1);
    doRead(3, 0, 0, 0);

    curReq = "R3";
    doWrite(5, 16'h1234, 0, 0);
    doWrite(5, 16'h5678, 0, 0);
    doRead(5, 0, 0, 0);

    curReq = "R4";
    doRead(DEPTH - 1, 1, 0, 0);
    doRead(DEPTH - 1, 0, 1, 0);
    doRead(DEPTH - 1, 1, 1, 0);

    curReq = "R5";
    doRead(0, 0, 0, 1);

    curReq = "R6";
    doIdle();
    doIdle();
    doRead(0, 0, 0, 0);

    curReq = "R7";
    for (int l = 0; l < 2; l++) begin
      for (int p = 0; p < 13; p++) begin
        doInject(7, l, 13'(1) << p);
        doRead(7, 0, 0, 0);
        doInject(7, l, 13'(1) << p);
      end
    end

    curReq = "R8";
    for (int l = 0; l < 2; l++) begin
      for (int p = 0; p < 13; p++) begin
        doInject(8, l, (13'(1) << p) | (13'(1) << ((p + 5) % 13)));
        doRead(8, 0, 0, 0);
        doInject(8, l, (13'(1) << p) | (13'(1) << ((p + 5) % 13)));
      end
    end

    curReq = "R9";
    doInject(9, 0, 13'h0010);
    doInject(9, 1, 13'h0006);
    doRead(9, 0, 0, 0);
    doWrite(10, 16'hBEEF, 0, 0);
    doInject(10, 0, 13'h1001);
    doInject(10, 1, 13'h0800);
    doRead(10, 0, 0, 0);

    curReq = "R10";
    doRead(9, 1, 0, 0);
    doRead(9, 0, 1, 0);
    doRead(10, 0, 1, 0);

    curReq = "R11";
    doInject(11, 1, 13'h0200);
    doRead(11, 0, 0, 0);
    doRead(11, 0, 0, 0);
    doWrite(11, 16'hC3C3, 0, 1);
    doRead(11, 0, 0, 0);

    curReq = "R12";
    csN = 0; weN = 0; oeN = 0; ubN = 1; lbN = 0; addr = AW'(12); wrData = 16'h5A5A;
    injEn = 1; injAddr = AW'(12); injLane = 1'b0; injMask = 13'h0040;
    step();
    csN = 0; weN = 0; oeN = 0; ubN = 1; lbN = 0; addr = AW'(12); wrData = 16'h3C3C;
    injEn = 1; injAddr = AW'(12); injLane = 1'b1; injMask = 13'h0008;
    step();
    injEn = 0;
    doRead(12, 0, 0, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule